// File: doc/BRIEF.md
# Change-of-State Event Capture Engine

This block watches a bank of digital input channels that have already been synchronized and debounced. It decides, clock by clock, whether a change on any channel counts as an event. Each channel carries a 2-bit edge-select code that picks which transitions matter. When at least one channel shows a selected transition, the whole input bank is logged into an internal data FIFO as a snapshot.

The block has two logging modes. In the plain mode one word is stored per event: the current state of all channels. In the sequence mode each event stores a pair of words: first the state of all channels in the clock before the event, then the current state. An optional timestamp, taken from an external counter value, can go into a second FIFO of its own. It stores one timestamp per event, so there is never more than one timestamp per pair.

The block pulses an interrupt request for every selected event, and this includes events that are dropped because the FIFO is full. It reports how many unread entries each FIFO holds and whether each is full. When an event or timestamp is lost, a sticky overflow flag is set. Software pops entries with read strobes. The head entry is always visible while a FIFO is not empty.

Top module: `evtCapture`

## Requirements
- R1: Each channel has the code {edgeSelFall, edgeSelRise}. Code 00 ignores the channel, 01 flags only rising transitions (0 to 1), 10 flags only falling transitions (1 to 0), and 11 flags both.
- R2: With seqMode=0, any flagged change on one or more channels in the same clock stores exactly one word, equal to the full current input bank.
- R3: With seqMode=1, each event stores two words in this order: the input bank of the previous clock, then the current input bank.
- R4: With stampEn=1, each stored event pushes exactly one stampValue (sampled in the event clock) into the timestamp FIFO. With stampEn=0, no timestamp is pushed.
- R5: The reference state is updated on every clock whether or not a change was flagged. An unflagged change therefore becomes the new reference, and it appears as the first word of a later pair.
- R6: After reset both counts are 0, overflow and irqReq are 0, and the first clock after reset only loads the reference, so it never produces an event.
- R7: The data FIFO holds DEPTH words, which is DEPTH events in plain mode and DEPTH/2 in sequence mode. An event that does not fit as a whole is dropped, and so is a timestamp that does not fit. A drop sets the sticky overflow flag, which is cleared by a data read strobe.
- R8: irqReq pulses high for one clock, one clock after each flagged event, if evtIrqEn was 1 in the event clock. This includes events dropped at full.
- R9: dataCount and stampCount give the number of unread entries. A read strobe pops the head, a read on an empty FIFO has no effect, and dataRdData and stampRdData show the head entry.
- R10: Events that arrive while entries are being read are still stored, and a pop and a push in the same clock leave the count consistent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanIn | input | NUM_CH | Debounced channel states |
| edgeSelRise | input | NUM_CH | Per-channel low code bit: flag rising transitions |
| edgeSelFall | input | NUM_CH | Per-channel high code bit: flag falling transitions |
| seqMode | input | 1 | 1 selects previous/current pair logging |
| stampEn | input | 1 | 1 pushes a timestamp per stored event |
| stampValue | input | STAMP_W | Counter value used as the timestamp |
| evtIrqEn | input | 1 | Enables the interrupt request pulse |
| dataRdEn | input | 1 | Pops the data FIFO head; clears overflow |
| dataRdData | output | NUM_CH | Data FIFO head word |
| dataCount | output | CW | Unread data words |
| dataFull | output | 1 | Data FIFO holds DEPTH words |
| stampRdEn | input | 1 | Pops the timestamp FIFO head |
| stampRdData | output | STAMP_W | Timestamp FIFO head |
| stampCount | output | CW | Unread timestamps |
| stampFull | output | 1 | Timestamp FIFO holds DEPTH entries |
| overflow | output | 1 | Sticky flag: an event or timestamp was dropped |
| irqReq | output | 1 | One-clock event request pulse |

## Verification
Single-channel toggles under each of the four edge codes show whether the rising and falling selections are separated correctly. They also show whether an ignored or an opposite-direction transition still moves the reference. A many-bit change in one clock shows whether several flagged channels collapse into a single stored word. In sequence mode, an unflagged change followed by a flagged one shows whether the first word of the pair really comes from the previous clock. Long runs of toggles in both modes fill the FIFO, including the case of a single free slot in sequence mode. Together with reads made during incoming events, these runs separate the pair admission, the overflow flag and the count bookkeeping from one another.

// File: rtl/evtCapturePkg.sv
package evtCapturePkg;
  // Strobes from the control to the datapath, valid in one clock
  typedef struct packed {
    logic pushWord;   // store the first word of an event
    logic pushPair;   // the event is a previous/current pair
    logic pushStamp;  // store one timestamp for the event
  } evtStrobeT;
endpackage

// File: rtl/evtFifo.sv
module evtFifo #(
  parameter int W     = 32,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pushA,
  input  logic          pushB,
  input  logic [W-1:0]  dataA,
  input  logic [W-1:0]  dataB,
  input  logic          rdEn,
  output logic [W-1:0]  rdData,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] nPush;
  logic          pop;

  assign pop    = rdEn && (count != '0);
  assign nPush  = pushB ? CW'(2) : (pushA ? CW'(1) : CW'(0));
  assign rdData = mem[rdPtr];
  assign full   = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (pushA) mem[wrPtr] <= dataA;
    if (pushB) mem[wrPtr + AW'(1)] <= dataB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + AW'(nPush);
      if (pop) rdPtr <= rdPtr + AW'(1);
      count <= count + nPush - (pop ? CW'(1) : CW'(0));
    end
  end
endmodule

// File: rtl/evtCaptureCtrl.sv
module evtCaptureCtrl
  import evtCapturePkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int DEPTH  = 512,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanIn,
  input  logic [NUM_CH-1:0] edgeSelRise,
  input  logic [NUM_CH-1:0] edgeSelFall,
  input  logic              seqMode,
  input  logic              stampEn,
  input  logic              evtIrqEn,
  input  logic              dataRdEn,
  input  logic [CW-1:0]     dataCount,
  input  logic [CW-1:0]     stampCount,
  output evtStrobeT         strobe,
  output logic [NUM_CH-1:0] prevWord,
  output logic              overflow,
  output logic              irqReq
);
  logic [NUM_CH-1:0] prevState;
  logic [NUM_CH-1:0] hitVec;
  logic              primed;
  logic              evtHit;
  logic [CW:0]       dataNeed;
  logic              dataRoom, stampRoom, dropEvt;

  // Per-channel edge qualification: code {fall, rise}
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    assign hitVec[ch] = (chanIn[ch] & ~prevState[ch] & edgeSelRise[ch]) |
                        (~chanIn[ch] & prevState[ch] & edgeSelFall[ch]);
  end

  assign evtHit    = primed && (|hitVec);
  assign dataNeed  = {1'b0, dataCount} + (seqMode ? (CW+1)'(2) : (CW+1)'(1));
  assign dataRoom  = (dataNeed <= (CW+1)'(DEPTH));
  assign stampRoom = (stampCount < CW'(DEPTH));
  assign dropEvt   = evtHit && (!dataRoom || (stampEn && !stampRoom));

  always_comb begin
    strobe.pushWord  = evtHit && dataRoom;
    strobe.pushPair  = evtHit && dataRoom && seqMode;
    strobe.pushStamp = evtHit && dataRoom && stampEn && stampRoom;
  end

  assign prevWord = prevState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevState <= '0;
      primed    <= 1'b0;
      overflow  <= 1'b0;
      irqReq    <= 1'b0;
    end else begin
      prevState <= chanIn;
      primed    <= 1'b1;
      irqReq    <= evtIrqEn && evtHit;
      if (dropEvt)       overflow <= 1'b1;
      else if (dataRdEn) overflow <= 1'b0;
    end
  end
endmodule

// File: rtl/evtCaptureDp.sv
module evtCaptureDp
  import evtCapturePkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int DEPTH   = 512,
  parameter int STAMP_W = 32,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  evtStrobeT          strobe,
  input  logic [NUM_CH-1:0]  prevWord,
  input  logic [NUM_CH-1:0]  chanIn,
  input  logic [STAMP_W-1:0] stampValue,
  input  logic               dataRdEn,
  input  logic               stampRdEn,
  output logic [NUM_CH-1:0]  dataRdData,
  output logic [CW-1:0]      dataCount,
  output logic               dataFull,
  output logic [STAMP_W-1:0] stampRdData,
  output logic [CW-1:0]      stampCount,
  output logic               stampFull
);
  logic [NUM_CH-1:0] firstWord;

  // A pair stores the reference first; a single event stores the current bank
  assign firstWord = strobe.pushPair ? prevWord : chanIn;

  evtFifo #(.W(NUM_CH), .DEPTH(DEPTH)) u_dataFifo (
    .clk    (clk),
    .rstN   (rstN),
    .pushA  (strobe.pushWord),
    .pushB  (strobe.pushPair),
    .dataA  (firstWord),
    .dataB  (chanIn),
    .rdEn   (dataRdEn),
    .rdData (dataRdData),
    .count  (dataCount),
    .full   (dataFull)
  );

  evtFifo #(.W(STAMP_W), .DEPTH(DEPTH)) u_stampFifo (
    .clk    (clk),
    .rstN   (rstN),
    .pushA  (strobe.pushStamp),
    .pushB  (1'b0),
    .dataA  (stampValue),
    .dataB  ('0),
    .rdEn   (stampRdEn),
    .rdData (stampRdData),
    .count  (stampCount),
    .full   (stampFull)
  );
endmodule

// File: rtl/evtCapture.sv
module evtCapture
  import evtCapturePkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int DEPTH   = 512,
  parameter int STAMP_W = 32,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CH-1:0]  chanIn,
  input  logic [NUM_CH-1:0]  edgeSelRise,
  input  logic [NUM_CH-1:0]  edgeSelFall,
  input  logic               seqMode,
  input  logic               stampEn,
  input  logic [STAMP_W-1:0] stampValue,
  input  logic               evtIrqEn,
  input  logic               dataRdEn,
  output logic [NUM_CH-1:0]  dataRdData,
  output logic [CW-1:0]      dataCount,
  output logic               dataFull,
  input  logic               stampRdEn,
  output logic [STAMP_W-1:0] stampRdData,
  output logic [CW-1:0]      stampCount,
  output logic               stampFull,
  output logic               overflow,
  output logic               irqReq
);
  evtStrobeT         strobe;
  logic [NUM_CH-1:0] prevWord;

  evtCaptureCtrl #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .chanIn      (chanIn),
    .edgeSelRise (edgeSelRise),
    .edgeSelFall (edgeSelFall),
    .seqMode     (seqMode),
    .stampEn     (stampEn),
    .evtIrqEn    (evtIrqEn),
    .dataRdEn    (dataRdEn),
    .dataCount   (dataCount),
    .stampCount  (stampCount),
    .strobe      (strobe),
    .prevWord    (prevWord),
    .overflow    (overflow),
    .irqReq      (irqReq)
  );

  evtCaptureDp #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .STAMP_W(STAMP_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .prevWord    (prevWord),
    .chanIn      (chanIn),
    .stampValue  (stampValue),
    .dataRdEn    (dataRdEn),
    .stampRdEn   (stampRdEn),
    .dataRdData  (dataRdData),
    .dataCount   (dataCount),
    .dataFull    (dataFull),
    .stampRdData (stampRdData),
    .stampCount  (stampCount),
    .stampFull   (stampFull)
  );
endmodule

// File: rtl/evtCaptureChk.sv
module evtCaptureChk #(
  parameter int NUM_CH = 32,
  parameter int DEPTH  = 512,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] chanIn,
  input logic              seqMode,
  input logic              evtIrqEn,
  input logic              dataRdEn,
  input logic [CW-1:0]     dataCount,
  input logic              dataFull,
  input logic              overflow,
  input logic              irqReq
);
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    int'(dataCount) <= DEPTH);

  assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dataFull && !dataRdEn) |=> dataFull);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !dataRdEn) |=> overflow);

  assert_irq_enabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> $past(evtIrqEn));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (int'(dataCount) <= int'($past(dataCount)) + 2) &&
             (int'(dataCount) + 1 >= int'($past(dataCount))));

  assert_cos_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!seqMode && !dataRdEn) |=> (int'(dataCount) <= int'($past(dataCount)) + 1));

  assert_change_needed_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dataCount > $past(dataCount)) |-> ($past(chanIn) != $past(chanIn, 2)));
endmodule

bind evtCapture evtCaptureChk #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/evtCapture_bench.sv
module evtCapture_bench;
  localparam int D = 512;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] chanIn, edgeSelRise, edgeSelFall, stampValue;
  logic        seqMode, stampEn, evtIrqEn, dataRdEn, stampRdEn;
  logic [31:0] dataRdData, stampRdData;
  logic [9:0]  dataCount, stampCount;
  logic        dataFull, stampFull, overflow, irqReq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evtCapture u_evtCapture (
    .clk(clk), .rstN(rstN), .chanIn(chanIn), .edgeSelRise(edgeSelRise),
    .edgeSelFall(edgeSelFall), .seqMode(seqMode), .stampEn(stampEn),
    .stampValue(stampValue), .evtIrqEn(evtIrqEn), .dataRdEn(dataRdEn),
    .dataRdData(dataRdData), .dataCount(dataCount), .dataFull(dataFull),
    .stampRdEn(stampRdEn), .stampRdData(stampRdData), .stampCount(stampCount),
    .stampFull(stampFull), .overflow(overflow), .irqReq(irqReq)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] mQ[$];
  logic [31:0] sQ[$];
  logic [31:0] mPrev;
  bit mPrimed, mOvf, mIrq, mHit, dRoom, sRoom;
  int mNeed;

  always @(posedge clk) begin
    if (!rstN) begin
      mQ.delete(); sQ.delete();
      mPrev = '0; mPrimed = 0; mOvf = 0; mIrq = 0;
    end else begin
      mHit = 0;
      if (mPrimed)
        for (int c = 0; c < 32; c++) begin
          if (!mPrev[c] && chanIn[c] && edgeSelRise[c]) mHit = 1;
          if (mPrev[c] && !chanIn[c] && edgeSelFall[c]) mHit = 1;
        end
      mNeed = seqMode ? 2 : 1;
      dRoom = (mQ.size() + mNeed) <= D;
      sRoom = sQ.size() < D;
      if (dataRdEn && mQ.size() > 0) void'(mQ.pop_front());
      if (stampRdEn && sQ.size() > 0) void'(sQ.pop_front());
      if (mHit && dRoom) begin
        if (seqMode) mQ.push_back(mPrev);
        mQ.push_back(chanIn);
        if (stampEn && sRoom) sQ.push_back(stampValue);
      end
      if (mHit && (!dRoom || (stampEn && !sRoom))) mOvf = 1;
      else if (dataRdEn) mOvf = 0;
      mIrq = evtIrqEn && mHit;
      mPrev = chanIn;
      mPrimed = 1;
    end
  end

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(int'(dataCount) == mQ.size(), "R9 dataCount", dataCount, mQ.size());
      chk(int'(stampCount) == sQ.size(), "R9 stampCount", stampCount, sQ.size());
      chk(dataFull == (mQ.size() == D), "R7 dataFull", dataFull, mQ.size() == D);
      if (mQ.size() > 0) chk(dataRdData == mQ[0], "R2 data head", dataRdData, mQ[0]);
      if (sQ.size() > 0) chk(stampRdData == sQ[0], "R4 stamp head", stampRdData, sQ[0]);
      chk(overflow == mOvf, "R7 overflow", overflow, mOvf);
      chk(irqReq == mIrq, "R8 irqReq", irqReq, mIrq);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drainAll();
    while (dataCount != 0 || stampCount != 0) begin
      dataRdEn = (dataCount != 0);
      stampRdEn = (stampCount != 0);
      @(negedge clk);
    end
    dataRdEn = 0; stampRdEn = 0;
  endtask

  task automatic toggleCh0(input int n);
    for (int i = 0; i < n; i++) begin
      chanIn = chanIn ^ 32'h1;
      @(negedge clk);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (!done && $time > 64'd500000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    rstN = 0; chanIn = 32'hFFFF_0000; edgeSelRise = '1; edgeSelFall = '1;
    seqMode = 0; stampEn = 0; stampValue = 0; evtIrqEn = 1;
    dataRdEn = 0; stampRdEn = 0;
    cyc(4);
    rstN = 1;
    cyc(3);
    // R6: reset state, and priming clock produces no event
    chk(dataCount == 0 && stampCount == 0, "R6 counts after reset", dataCount, 0);
    chk(!overflow && !irqReq, "R6 flags after reset", {overflow, irqReq}, 0);

    // R1: any-edge code 11 flags a rising change
    chanIn = 32'hFFFF_0001; cyc(1);
    chk(dataCount == 1, "R1 any-edge count", dataCount, 1);
    chk(dataRdData == 32'hFFFF_0001, "R2 snapshot word", dataRdData, 32'hFFFF_0001);
    chk(irqReq == 1, "R8 irq pulse", irqReq, 1);
    cyc(1);
    chk(irqReq == 0, "R8 irq is one clock", irqReq, 0);
    drainAll();

    // R1: ch0=01 rise, ch1=10 fall, ch2=11 any, ch3=00 ignore, others 00
    edgeSelRise = 32'h5; edgeSelFall = 32'h6; cyc(1);
    chanIn = 32'h0; cyc(1);
    chk(dataCount == 0, "R1 ignored falls", dataCount, 0);
    chanIn = 32'h8; cyc(1); chanIn = 32'h0; cyc(1);
    chk(dataCount == 0, "R1 code 00 ignored", dataCount, 0);
    chanIn = 32'h1; cyc(1); chanIn = 32'h0; cyc(1);
    chk(dataCount == 1, "R1 rise-only", dataCount, 1);
    chanIn = 32'h2; cyc(1); chanIn = 32'h0; cyc(1);
    chk(dataCount == 2, "R1 fall-only", dataCount, 2);
    chanIn = 32'h4; cyc(1); chanIn = 32'h0; cyc(1);
    chk(dataCount == 4, "R1 any-edge both", dataCount, 4);
    drainAll();

    // R2: many channels change in one clock -> one word
    edgeSelRise = '1; edgeSelFall = '1; cyc(1);
    chanIn = 32'hA5A5_A5A5; cyc(1);
    chk(dataCount == 1, "R2 one word for many channels", dataCount, 1);
    chk(dataRdData == 32'hA5A5_A5A5, "R2 word value", dataRdData, 32'hA5A5_A5A5);
    drainAll();

    // R3/R4/R5: pair logging with a timestamp; unflagged change becomes reference
    edgeSelRise = 32'h1; edgeSelFall = 32'h0; seqMode = 1; stampEn = 1; cyc(1);
    chanIn = 32'h0; cyc(1);
    chanIn = 32'h10; cyc(1);
    chk(dataCount == 0, "R5 unflagged change not stored", dataCount, 0);
    chanIn = 32'h11; stampValue = 32'h1234; cyc(1);
    chk(dataCount == 2, "R3 pair count", dataCount, 2);
    chk(dataRdData == 32'h10, "R5 previous word is new reference", dataRdData, 32'h10);
    chk(stampCount == 1 && stampRdData == 32'h1234, "R4 one stamp per pair", stampRdData, 32'h1234);
    dataRdEn = 1; cyc(1); dataRdEn = 0;
    chk(dataRdData == 32'h11, "R3 current word second", dataRdData, 32'h11);
    stampEn = 0;
    chanIn = 32'h10; cyc(1); chanIn = 32'h11; cyc(1);
    chk(stampCount == 1, "R4 no stamp when disabled", stampCount, 1);
    drainAll();

    // R7/R8: fill in plain mode
    seqMode = 0; edgeSelRise = 32'h1; edgeSelFall = 32'h1; cyc(1);
    toggleCh0(600);
    chk(dataCount == D && dataFull, "R7 plain capacity", dataCount, D);
    chk(overflow == 1, "R7 overflow set", overflow, 1);
    chk(irqReq == 1, "R8 irq on dropped event", irqReq, 1);
    dataRdEn = 1; cyc(1); dataRdEn = 0;
    chk(overflow == 0 && dataCount == D - 1, "R7 read clears overflow", overflow, 0);

    // R10: events during reads are stored
    dataRdEn = 1; toggleCh0(10); dataRdEn = 0;
    chk(dataCount == D - 1 && overflow == 0, "R10 push and pop together", dataCount, D - 1);
    drainAll();

    // R7: fill in sequence mode, and a single free slot rejects a pair
    seqMode = 1; cyc(1);
    toggleCh0(300);
    chk(dataCount == D, "R7 sequence capacity", dataCount, D);
    dataRdEn = 1; cyc(1); dataRdEn = 0;
    toggleCh0(1);
    chk(dataCount == D - 1 && overflow == 1, "R7 pair rejected whole", dataCount, D - 1);
    drainAll();

    // R8: interrupts disabled
    seqMode = 0; evtIrqEn = 0; cyc(1);
    toggleCh0(1);
    chk(irqReq == 0 && dataCount == 1, "R8 no irq when disabled", irqReq, 0);
    drainAll();

    // R9: read on empty has no effect
    dataRdEn = 1; stampRdEn = 1; cyc(1); dataRdEn = 0; stampRdEn = 0;
    chk(dataCount == 0 && stampCount == 0, "R9 empty read ignored", dataCount, 0);
    toggleCh0(1);
    chk(dataCount == 1 && dataRdData == chanIn, "R9 head after empty read", dataRdData, chanIn);
    drainAll();
    cyc(2);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule